// File: doc/BRIEF.md
# Oscillator Power and Clock-Source Handover Controller

This block decides which of two oscillators, an on-die RC oscillator and an external crystal, is powered at any moment, and which one drives the system clock. Software writes two small registers. The first holds two keep-alive bits, one for each oscillator. The second holds the crystal-select bit, a six-bit auxiliary field and a read-only RC-mode status bit. A warm-up counter stands in for the analog ready detector of the crystal. The counter starts when crystal power comes up and reports ready after a fixed number of cycles.

A handover engine moves the clock source from one oscillator to the other. It first shuts the gate of the old source. Next, while both gates are closed, it flips the mux select. Only then does it open the gate of the new source. A request for the crystal waits until the crystal is warm. A request for RC is served at once. The select bit survives every reset except power-on. A resume from stop mode restarts crystal warm-up and runs the clock from RC until the crystal is warm again.

Top module: `osc_clk_ctrl`

## Requirements
- R1: The oscillator register reads 0x0001 after either reset. Bit 0 is the RC keep-alive bit and bit 1 is the crystal keep-alive bit. These are the only writable bits (write address 0), and bits 15..2 always read 0.
- R2: The clock register (write address 1) places crystal-select at bit 7, RC-mode status at bit 6 and the auxiliary field at bits 5..0. Crystal-select is cleared only by `rst_por`. `rst_sys` leaves it unchanged and clears only the auxiliary field. Writes to bit 6 are ignored.
- R3: `xtal_pwr` is 1 whenever the crystal keep-alive bit is set, crystal-select is 1, or the crystal is still clocking (its gate is open or its handover is under way). Otherwise it is 0.
- R4: `rc_pwr` is 1 when any of these holds: the RC keep-alive bit is set, crystal-select is 0, `wdt_active` is 1, `flash_busy` is 1, or the crystal gate is closed. Otherwise `rc_pwr` is 0.
- R5: `xtal_ready` rises exactly WARM_CYC clock edges after the edge at which `xtal_pwr` became 1. It drops one edge after power is removed.
- R6: If crystal-select is written to 1 while `xtal_ready` is 1, `gate_rc` falls and `mux_xtal` rises one edge after the write. `gate_xtal` rises one edge after that.
- R7: If crystal-select is set before the crystal is warm, `gate_rc` stays 1 until `xtal_ready` rises. The crystal gate opens two edges after `xtal_ready` rises.
- R8: `gate_rc` and `gate_xtal` are never both 1. `mux_xtal` changes only in a cycle in which both gates are 0.
- R9: Writing crystal-select from 1 to 0 closes the crystal gate one edge later and opens the RC gate one edge after that. Crystal power then drops unless its keep-alive bit is set.
- R10: RC-mode status equals the inverse of crystal-select, except after a `stop_resume` pulse while crystal-select is 1 and the crystal keep-alive bit is 0. Such a pulse restarts warm-up, returns the clock to RC, and holds RC-mode at 1 until the crystal gate reopens. With the crystal keep-alive bit set, `stop_resume` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_sys | input | 1 | Any other reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the oscillator register, 1 the clock register |
| wr_data | input | 16 | Write data (clock register uses bits 7..0) |
| wdt_active | input | 1 | Watchdog is running and needs RC |
| flash_busy | input | 1 | Flash program or erase in progress |
| stop_resume | input | 1 | One-cycle pulse on wake-up from stop mode |
| osc_rd | output | 16 | Oscillator register read value |
| clk_rd | output | 8 | Clock register read value |
| rc_pwr | output | 1 | RC oscillator power enable |
| xtal_pwr | output | 1 | Crystal oscillator power enable |
| xtal_ready | output | 1 | Crystal warm-up complete |
| gate_rc | output | 1 | RC clock gate open |
| gate_xtal | output | 1 | Crystal clock gate open |
| mux_xtal | output | 1 | Clock mux selects the crystal |

## Verification
The bench builds the block with WARM_CYC set to 8. This makes it practical to step every edge of a warm-up, both handover gaps, and the full stop-resume recovery, and to compare each of them against edge counts worked out by hand. With warm-up this short, the bench can also sweep every combination of the two keep-alive bits with the watchdog and flash inputs, running the sweep once with RC as the clock source and once with the crystal.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

    localparam int OSC_REG_W = 16;
    localparam int CLK_REG_W = 8;
    localparam int AUX_W     = 6;

    localparam logic ADDR_OSC = 1'b0;
    localparam logic ADDR_CLK = 1'b1;

    localparam logic [OSC_REG_W-1:0] OSC_RESET_VAL = 16'h0001;

    // Clock-source handover states: each swap passes through a gap state.
    typedef enum logic [1:0] {
        SRC_RC   = 2'd0,
        GAP_TO_X = 2'd1,
        SRC_X    = 2'd2,
        GAP_TO_R = 2'd3
    } src_state_e;

    typedef struct packed {
        logic xtal_keep;
        logic rc_keep;
    } osc_keep_t;

    typedef struct packed {
        logic             use_xtal;
        logic [AUX_W-1:0] aux;
    } clk_ctl_t;

    function automatic logic [OSC_REG_W-1:0] pack_osc(osc_keep_t k);
        return {{(OSC_REG_W-2){1'b0}}, k.xtal_keep, k.rc_keep};
    endfunction

    function automatic logic [CLK_REG_W-1:0] pack_clk(clk_ctl_t c, logic rc_mode);
        return {c.use_xtal, rc_mode, c.aux};
    endfunction

    // Crystal is still the live source (gate open or closing).
    function automatic logic xtal_clocking(src_state_e s);
        return (s == SRC_X) || (s == GAP_TO_R);
    endfunction

endpackage

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
    import osc_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_por,
    input  logic                 rst_sys,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [OSC_REG_W-1:0] wr_data,
    input  logic                 stop_resume,
    input  logic                 in_gap_to_x,
    output osc_keep_t            keep,
    output clk_ctl_t             ctl,
    output logic                 resume_hold,
    output logic                 warm_restart
);

    logic any_rst;
    logic wr_osc;
    logic wr_clk;

    assign any_rst = rst_por | rst_sys;
    assign wr_osc  = wr_en && (wr_addr == ADDR_OSC);
    assign wr_clk  = wr_en && (wr_addr == ADDR_CLK);

    // Stop-mode wake restarts crystal warm-up unless it was kept alive.
    assign warm_restart = stop_resume & ~keep.xtal_keep;

    // Keep-alive bits: every reset returns them to the reset pattern.
    always_ff @(posedge clk) begin
        if (any_rst) begin
            keep.xtal_keep <= OSC_RESET_VAL[1];
            keep.rc_keep   <= OSC_RESET_VAL[0];
        end else if (wr_osc) begin
            keep.xtal_keep <= wr_data[1];
            keep.rc_keep   <= wr_data[0];
        end
    end

    // Crystal-select: only power-on reset clears it; other resets hold it.
    always_ff @(posedge clk) begin
        if (rst_por) begin
            ctl.use_xtal <= 1'b0;
        end else if (wr_clk && !rst_sys) begin
            ctl.use_xtal <= wr_data[CLK_REG_W-1];
        end
    end

    // Auxiliary field: cleared by any reset.
    always_ff @(posedge clk) begin
        if (any_rst) begin
            ctl.aux <= '0;
        end else if (wr_clk) begin
            ctl.aux <= wr_data[AUX_W-1:0];
        end
    end

    // Resume window: set on wake with crystal selected, cleared as the
    // crystal gate is about to reopen.
    always_ff @(posedge clk) begin
        if (any_rst) begin
            resume_hold <= 1'b0;
        end else if (warm_restart && ctl.use_xtal) begin
            resume_hold <= 1'b1;
        end else if (in_gap_to_x) begin
            resume_hold <= 1'b0;
        end
    end

endmodule

// File: rtl/xtal_warm_ctr.sv
module xtal_warm_ctr #(
    parameter int WARM_CYC = 64
) (
    input  logic clk,
    input  logic rst_por,
    input  logic pwr,
    input  logic restart,
    output logic ready
);

    localparam int CNT_W = (WARM_CYC < 2) ? 1 : $clog2(WARM_CYC + 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(WARM_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst_por || !pwr || restart) begin
            cnt <= '0;
        end else if (cnt != DONE) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == DONE);

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import osc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_por,
    input  logic       want_xtal,
    output src_state_e state,
    output logic       gate_rc,
    output logic       gate_xtal,
    output logic       mux_xtal
);

    src_state_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            SRC_RC:   if (want_xtal)  state_n = GAP_TO_X;
            GAP_TO_X: state_n = want_xtal ? SRC_X : GAP_TO_R;
            SRC_X:    if (!want_xtal) state_n = GAP_TO_R;
            GAP_TO_R: state_n = SRC_RC;
            default:  state_n = SRC_RC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_por) begin
            state <= SRC_RC;
        end else begin
            state <= state_n;
        end
    end

    assign gate_rc   = (state == SRC_RC);
    assign gate_xtal = (state == SRC_X);
    assign mux_xtal  = (state == GAP_TO_X) || (state == SRC_X);

endmodule

// File: rtl/osc_clk_ctrl.sv
module osc_clk_ctrl
    import osc_ctrl_pkg::*;
#(
    parameter int WARM_CYC = 64
) (
    input  logic        clk,
    input  logic        rst_por,
    input  logic        rst_sys,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [15:0] wr_data,
    input  logic        wdt_active,
    input  logic        flash_busy,
    input  logic        stop_resume,
    output logic [15:0] osc_rd,
    output logic [7:0]  clk_rd,
    output logic        rc_pwr,
    output logic        xtal_pwr,
    output logic        xtal_ready,
    output logic        gate_rc,
    output logic        gate_xtal,
    output logic        mux_xtal
);

    osc_keep_t  keep;
    clk_ctl_t   ctl;
    src_state_e state;
    logic       resume_hold;
    logic       warm_restart;
    logic       want_xtal;
    logic       rc_mode;

    osc_cfg_regs u_regs (
        .clk          (clk),
        .rst_por      (rst_por),
        .rst_sys      (rst_sys),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .stop_resume  (stop_resume),
        .in_gap_to_x  (state == GAP_TO_X),
        .keep         (keep),
        .ctl          (ctl),
        .resume_hold  (resume_hold),
        .warm_restart (warm_restart)
    );

    assign xtal_pwr = keep.xtal_keep | ctl.use_xtal | xtal_clocking(state);

    xtal_warm_ctr #(
        .WARM_CYC (WARM_CYC)
    ) u_warm (
        .clk     (clk),
        .rst_por (rst_por),
        .pwr     (xtal_pwr),
        .restart (warm_restart),
        .ready   (xtal_ready)
    );

    assign want_xtal = ctl.use_xtal & xtal_ready;

    clk_src_switch u_switch (
        .clk       (clk),
        .rst_por   (rst_por),
        .want_xtal (want_xtal),
        .state     (state),
        .gate_rc   (gate_rc),
        .gate_xtal (gate_xtal),
        .mux_xtal  (mux_xtal)
    );

    assign rc_pwr  = keep.rc_keep | ~ctl.use_xtal | wdt_active | flash_busy | ~gate_xtal;
    assign rc_mode = ~ctl.use_xtal | resume_hold;

    assign osc_rd = pack_osc(keep);
    assign clk_rd = pack_clk(ctl, rc_mode);

endmodule

// File: rtl/osc_clk_ctrl_chk.sv
module osc_clk_ctrl_chk (
    input logic        clk,
    input logic        rst_por,
    input logic        rst_sys,
    input logic        wr_en,
    input logic        wr_addr,
    input logic [15:0] wr_data,
    input logic        wdt_active,
    input logic        flash_busy,
    input logic        stop_resume,
    input logic [15:0] osc_rd,
    input logic [7:0]  clk_rd,
    input logic        rc_pwr,
    input logic        xtal_pwr,
    input logic        xtal_ready,
    input logic        gate_rc,
    input logic        gate_xtal,
    input logic        mux_xtal
);

    p_osc_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst_por)
        osc_rd[15:2] == 14'd0);

    p_sel_holds_sysrst_r2: assert property (@(posedge clk) disable iff (rst_por)
        rst_sys |=> $stable(clk_rd[7]));

    p_xtal_pwr_r3: assert property (@(posedge clk) disable iff (rst_por)
        (osc_rd[1] || clk_rd[7]) |-> xtal_pwr);

    p_rc_pwr_r4: assert property (@(posedge clk) disable iff (rst_por)
        (osc_rd[0] || !clk_rd[7] || wdt_active || flash_busy) |-> rc_pwr);

    p_ready_powered_r5: assert property (@(posedge clk) disable iff (rst_por)
        xtal_ready |-> $past(xtal_pwr));

    p_xtal_gate_warm_r6: assert property (@(posedge clk) disable iff (rst_por)
        $rose(gate_xtal) |-> $past(xtal_ready));

    p_gates_exclusive_r8: assert property (@(posedge clk) disable iff (rst_por)
        !(gate_rc && gate_xtal));

    p_mux_in_gap_r8: assert property (@(posedge clk) disable iff (rst_por)
        (mux_xtal != $past(mux_xtal)) |-> (!gate_rc && !gate_xtal));

    p_rc_mode_r10: assert property (@(posedge clk) disable iff (rst_por)
        !clk_rd[7] |-> clk_rd[6]);

endmodule

bind osc_clk_ctrl osc_clk_ctrl_chk u_chk (.*);

// File: tb/osc_clk_ctrl_test.sv
module osc_clk_ctrl_test;

    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst_por = 1'b1;
    logic        rst_sys = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wdt_active = 1'b0;
    logic        flash_busy = 1'b0;
    logic        stop_resume = 1'b0;
    logic [15:0] osc_rd;
    logic [7:0]  clk_rd;
    logic        rc_pwr, xtal_pwr, xtal_ready, gate_rc, gate_xtal, mux_xtal;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    osc_clk_ctrl #(.WARM_CYC(W)) uut (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wdt_active(wdt_active), .flash_busy(flash_busy), .stop_resume(stop_resume),
        .osc_rd(osc_rd), .clk_rd(clk_rd), .rc_pwr(rc_pwr), .xtal_pwr(xtal_pwr),
        .xtal_ready(xtal_ready), .gate_rc(gate_rc), .gate_xtal(gate_xtal),
        .mux_xtal(mux_xtal)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        step(3);
        rst_por = 1'b0;
        step(1);
        // Reset state
        chk("R1", "osc after por", osc_rd, 16'h0001);
        chk("R2", "clk after por", {8'h0, clk_rd}, 16'h0040);
        chk("R8", "gate_rc after por", {15'd0, gate_rc}, 16'd1);
        chk("R8", "gate_xtal after por", {15'd0, gate_xtal}, 16'd0);
        chk("R5", "ready after por", {15'd0, xtal_ready}, 16'd0);

        // R1: only two writable bits
        wr(1'b0, 16'hFFFF);
        chk("R1", "osc all ones", osc_rd, 16'h0003);

        // R3/R4 sweep with RC as source
        for (int v = 0; v < 16; v++) begin
            wr(1'b0, 16'(v[1:0]));
            wdt_active = v[2]; flash_busy = v[3];
            step(1);
            chk("R1", "osc readback", osc_rd, 16'(v[1:0]));
            chk("R3", "xtal_pwr on rc", {15'd0, xtal_pwr}, {15'd0, v[1]});
            chk("R4", "rc_pwr on rc", {15'd0, rc_pwr}, 16'd1);
        end
        wdt_active = 1'b0; flash_busy = 1'b0;
        wr(1'b0, 16'h0000);
        step(1);

        // R5: warm-up length via crystal keep-alive
        wr(1'b0, 16'h0002);
        for (int k = 1; k <= W + 1; k++) begin
            step(1);
            chk("R5", "ready during warmup", {15'd0, xtal_ready}, {15'd0, k >= W});
        end

        // R6: select crystal when already warm
        wr(1'b1, 16'h0080);
        chk("R6", "gate_rc edge0", {15'd0, gate_rc}, 16'd1);
        chk("R6", "mux edge0", {15'd0, mux_xtal}, 16'd0);
        step(1);
        chk("R6", "gate_rc edge1", {15'd0, gate_rc}, 16'd0);
        chk("R6", "gate_xtal edge1", {15'd0, gate_xtal}, 16'd0);
        chk("R6", "mux edge1", {15'd0, mux_xtal}, 16'd1);
        step(1);
        chk("R6", "gate_xtal edge2", {15'd0, gate_xtal}, 16'd1);
        chk("R10", "rc_mode on crystal", {8'h0, clk_rd}, 16'h0080);

        // R4/R3 sweep with crystal as source
        for (int v = 0; v < 16; v++) begin
            wr(1'b0, 16'(v[1:0]));
            wdt_active = v[2]; flash_busy = v[3];
            step(1);
            chk("R4", "rc_pwr on xtal", {15'd0, rc_pwr}, {15'd0, v[0] | v[2] | v[3]});
            chk("R3", "xtal_pwr on xtal", {15'd0, xtal_pwr}, 16'd1);
        end
        wdt_active = 1'b0; flash_busy = 1'b0;
        wr(1'b0, 16'h0000);

        // R2: aux field, read-only status bit, reset behaviour
        wr(1'b1, 16'h00BF);
        chk("R2", "clk aux write", {8'h0, clk_rd}, 16'h00BF);
        wr(1'b1, 16'h00C5);
        chk("R2", "bit6 write ignored", {8'h0, clk_rd}, 16'h0085);
        @(negedge clk); rst_sys = 1'b1;
        @(negedge clk); rst_sys = 1'b0;
        chk("R2", "clk after sysrst", {8'h0, clk_rd}, 16'h0080);
        chk("R1", "osc after sysrst", osc_rd, 16'h0001);
        chk("R2", "crystal kept after sysrst", {15'd0, gate_xtal}, 16'd1);

        // R9: back to RC
        wr(1'b1, 16'h0000);
        chk("R9", "rc_mode edge0", {8'h0, clk_rd}, 16'h0040);
        chk("R9", "gate_xtal edge0", {15'd0, gate_xtal}, 16'd1);
        step(1);
        chk("R9", "gap gate_xtal", {15'd0, gate_xtal}, 16'd0);
        chk("R9", "gap gate_rc", {15'd0, gate_rc}, 16'd0);
        chk("R9", "xtal_pwr in gap", {15'd0, xtal_pwr}, 16'd1);
        step(1);
        chk("R9", "gate_rc edge2", {15'd0, gate_rc}, 16'd1);
        chk("R9", "xtal_pwr off", {15'd0, xtal_pwr}, 16'd0);
        step(1);
        chk("R5", "ready drops", {15'd0, xtal_ready}, 16'd0);

        // R7: select crystal while cold
        wr(1'b1, 16'h0080);
        for (int k = 1; k <= W + 2; k++) begin
            step(1);
            chk("R7", "gate_rc cold", {15'd0, gate_rc}, {15'd0, k <= W});
            chk("R7", "gate_xtal cold", {15'd0, gate_xtal}, {15'd0, k >= W + 2});
            chk("R10", "rc_mode cold select", {15'd0, clk_rd[6]}, 16'd0);
        end

        // R10: stop-mode resume with crystal selected
        @(negedge clk); stop_resume = 1'b1;
        @(negedge clk); stop_resume = 1'b0;
        chk("R10", "rc_mode after resume", {8'h0, clk_rd}, 16'h00C0);
        chk("R10", "ready cleared", {15'd0, xtal_ready}, 16'd0);
        for (int k = 1; k <= W + 2; k++) begin
            step(1);
            chk("R10", "rc_mode window", {15'd0, clk_rd[6]}, {15'd0, k < W + 2});
            chk("R10", "gate_xtal resume", {15'd0, gate_xtal}, {15'd0, k >= W + 2});
            chk("R10", "gate_rc resume", {15'd0, gate_rc}, {15'd0, k >= 2 && k <= W});
        end

        // R10: resume ignored with crystal keep-alive
        wr(1'b0, 16'h0002);
        @(negedge clk); stop_resume = 1'b1;
        @(negedge clk); stop_resume = 1'b0;
        step(2);
        chk("R10", "kept ready", {15'd0, xtal_ready}, 16'd1);
        chk("R10", "kept clk_rd", {8'h0, clk_rd}, 16'h0080);
        chk("R10", "kept gate_xtal", {15'd0, gate_xtal}, 16'd1);

        // R2: power-on reset clears select
        @(negedge clk); rst_por = 1'b1;
        step(2); rst_por = 1'b0;
        step(1);
        chk("R2", "clk after second por", {8'h0, clk_rd}, 16'h0040);
        chk("R1", "osc after second por", osc_rd, 16'h0001);
        chk("R8", "gate_rc after second por", {15'd0, gate_rc}, 16'd1);
        chk("R5", "ready after second por", {15'd0, xtal_ready}, 16'd0);

        summary();
        $finish;
    end

endmodule